// File: doc/BRIEF.md
# Debug-Port Command Bridge

This block gives a debug host a small register path into the chip through the scan port. The block sits behind a user data register of the chip's test access port. It uses the TAP's select, capture, shift and update strobes, together with the scan clock and the serial data lines. The host scans in one 16-bit command word. When the host returns the port to idle, the update event turns that word into a single transaction on an internal byte-wide peripheral bus, which runs in the system clock domain.

The command word is made of three fields. Bits 15:12 name the peripheral. Bits 11:8 carry the opcode. Bits 7:0 carry the data byte. Opcode 0x0 writes the data byte, and opcode 0x1 reads one byte. The next scan returns the byte that was read, below a copy of the command header. Three peripherals are attached:
- a control register that drives `ctrl_out`;
- a read-only view of the status lines `sts_in`;
- a selector that routes one byte of the probe lines to `mon_out`.

Top module: `jtag_cmd_bridge`

## Requirements
- R1: The 16-bit shift register loads on a capture and shifts on a shift strobe, but only while `usr_sel` is high. Data enters on `tdi` least significant bit first. `tdo` always shows bit 0 of the register. While `usr_sel` is low, neither strobe changes the register.
- R2: An update with `usr_sel` high latches the shifted word as the command. Bits 15:12 are the peripheral number, bits 11:8 are the opcode and bits 7:0 are the data byte. An update with `usr_sel` low leaves the command unchanged and starts no transaction.
- R3: A command with opcode 0x0 to an attached peripheral gives exactly one `bus_wr` pulse, one system clock long. During the pulse, `bus_sel` equals bits 15:12 and `bus_wdata` equals bits 7:0. A write never coincides with `bus_rd`.
- R4: A command with opcode 0x1 to an attached peripheral gives exactly one `bus_rd` pulse and latches that peripheral's read byte. The next capture loads bits 15:8 of the latest command into bits 15:8 of the register, and the latched byte into bits 7:0.
- R5: Opcodes 0x2 to 0xF produce no strobe. Their response byte is 0x00.
- R6: The attached peripheral numbers are 0, 1 and 2. A command to peripheral numbers 3 to 15 produces no strobe, and a read from them returns 0x00.
- R7: A write to peripheral 0 loads the control register. The register drives `ctrl_out` and reads back through peripheral 0.
- R8: A read of peripheral 1 returns `sts_in`. A write to peripheral 1 changes no state.
- R9: A write to peripheral 2 loads the selector register, which reads back in full. When the selector's bits 2:0 hold an index below NPROBE, `mon_out` equals byte number index of `probe_in`. For any other index, `mon_out` is 0x00.
- R10: After both resets, the control register, the selector, the command and the response byte are all zero. The first capture therefore returns 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset, system domain |
| tck | input | 1 | Scan clock |
| tap_rst_n | input | 1 | Synchronous active-low reset, scan domain |
| usr_sel | input | 1 | User data register selected |
| usr_capture | input | 1 | Capture strobe |
| usr_shift | input | 1 | Shift strobe |
| usr_update | input | 1 | Update strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, bit 0 of the shift register |
| sts_in | input | 8 | Status lines read by peripheral 1 |
| probe_in | input | NPROBE*8 | Probe bytes routed by peripheral 2 |
| ctrl_out | output | 8 | Control register value |
| mon_out | output | 8 | Selected probe byte |
| bus_sel | output | 4 | Peripheral number of the current command |
| bus_wr | output | 1 | Write strobe, one system clock |
| bus_rd | output | 1 | Read strobe, one system clock |
| bus_wdata | output | 8 | Write data byte |

## Verification
The hardest situations to reach are the ones where the serial path itself is disturbed. One is a capture or shift strobe that arrives while the register is deselected, in the middle of a scan. The other is an update with the select line low. In both cases, nothing may reach the bus, and the echoed command header must stay unchanged.

The stimulus inserts deselected shift cycles with random `tdi` halfway through one scan, and then checks that the shifted-out bits are still intact. It ends another scan with an update while the select line is low. It then uses the next capture to show that the header did not move and that no strobe appeared.

Random words spread over all 16 peripheral numbers and all opcodes. Every read response arrives one scan late, so the bench checks it through the following scan.

// File: rtl/jcb_pkg.sv
`timescale 1ns/1ps
// Package: command layout, opcodes and peripheral numbers shared by the bridge.
package jcb_pkg;
    localparam int CMD_W  = 16;
    localparam int DATA_W = 8;
    localparam int PID_W  = 4;
    localparam int OP_W   = 4;

    typedef struct packed {
        logic [PID_W-1:0]  pid;
        logic [OP_W-1:0]   op;
        logic [DATA_W-1:0] data;
    } cmd_t;

    localparam logic [OP_W-1:0]  OP_WRITE = 4'h0;
    localparam logic [OP_W-1:0]  OP_READ  = 4'h1;

    localparam logic [PID_W-1:0] PID_CTRL = 4'd0;
    localparam logic [PID_W-1:0] PID_STAT = 4'd1;
    localparam logic [PID_W-1:0] PID_MUX  = 4'd2;

    // True when a peripheral answers at this number.
    function automatic logic is_attached(input logic [PID_W-1:0] pid);
        return (pid == PID_CTRL) || (pid == PID_STAT) || (pid == PID_MUX);
    endfunction
endpackage

// File: rtl/jcb_shift.sv
`timescale 1ns/1ps
// Module: jcb_shift
// Scan-clock side. Holds the user data register and the latched command.
// Each selected update flips a toggle that the system domain watches.
// Assumes: the response byte from the system domain is steady at capture time,
// because the host waits between scans.
module jcb_shift
    import jcb_pkg::*;
(
    input  logic              tck,
    input  logic              tap_rst_n,
    input  logic              usr_sel,
    input  logic              usr_capture,
    input  logic              usr_shift,
    input  logic              usr_update,
    input  logic              tdi,
    input  logic [DATA_W-1:0] rsp_byte,
    output logic              tdo,
    output cmd_t              cmd,
    output logic              upd_toggle
);
    logic [CMD_W-1:0] sr_q;

    // Shift register: capture loads header echo plus response, shift moves toward bit 0.
    always_ff @(posedge tck) begin
        if (!tap_rst_n)
            sr_q <= '0;
        else if (usr_sel && usr_capture)
            sr_q <= {cmd.pid, cmd.op, rsp_byte};
        else if (usr_sel && usr_shift)
            sr_q <= {tdi, sr_q[CMD_W-1:1]};
    end

    // Command latch and update toggle: one flip per selected update.
    always_ff @(posedge tck) begin
        if (!tap_rst_n) begin
            cmd        <= '0;
            upd_toggle <= 1'b0;
        end else if (usr_sel && usr_update) begin
            cmd        <= cmd_t'(sr_q);
            upd_toggle <= ~upd_toggle;
        end
    end

    assign tdo = sr_q[0];

    AST_SR_IDLE_STABLE: assert property (@(posedge tck) disable iff (!tap_rst_n)
        !usr_sel |=> $stable(sr_q)); // R1
    AST_CMD_HELD: assert property (@(posedge tck) disable iff (!tap_rst_n)
        !(usr_sel && usr_update) |=> $stable(cmd)); // R2
    AST_TOGGLE_ON_UPDATE: assert property (@(posedge tck) disable iff (!tap_rst_n)
        (usr_sel && usr_update) |=> (upd_toggle != $past(upd_toggle))); // R2
endmodule

// File: rtl/jcb_sync.sv
`timescale 1ns/1ps
// Module: jcb_sync
// Carries the scan-domain update toggle into the system clock domain.
// Turns each change of the toggle into a one-cycle pulse.
// Assumes: toggles are spaced by many system clocks (one full scan apart).
module jcb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tog_in,
    output logic pulse
);
    localparam int CHAIN = STAGES + 1;
    logic [CHAIN-1:0] sync_q;

    // Synchronizer chain plus one stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[CHAIN-2:0], tog_in};
    end

    // Registered pulse on any change of the synchronized toggle.
    always_ff @(posedge clk) begin
        if (!rst_n) pulse <= 1'b0;
        else        pulse <= sync_q[CHAIN-2] ^ sync_q[CHAIN-1];
    end

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse); // R3
endmodule

// File: rtl/jcb_dispatch.sv
`timescale 1ns/1ps
// Module: jcb_dispatch
// Decodes the latched command when the update pulse arrives.
// Raises one write or read strobe, and keeps the response byte for the next capture.
// Assumes: the command stays unchanged from its update until well after the pulse.
module jcb_dispatch
    import jcb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  cmd_t              cmd,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic [PID_W-1:0]  bus_sel,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_wr,
    output logic              bus_rd,
    output logic [DATA_W-1:0] rsp_byte
);
    logic att;
    logic is_wr;
    logic is_rd;

    // Decode of the held command word.
    always_comb begin
        att   = is_attached(cmd.pid);
        is_wr = (cmd.op == OP_WRITE) && att;
        is_rd = (cmd.op == OP_READ) && att;
    end

    assign bus_sel   = cmd.pid;
    assign bus_wdata = cmd.data;

    // Strobe generation: one cycle per update pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_wr <= 1'b0;
            bus_rd <= 1'b0;
        end else begin
            bus_wr <= go && is_wr;
            bus_rd <= go && is_rd;
        end
    end

    // Response byte: read data on a read strobe, cleared by any other command.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rsp_byte <= '0;
        else if (bus_rd)
            rsp_byte <= bus_rdata;
        else if (go && !is_rd)
            rsp_byte <= '0;
    end

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_rd)); // R3
    AST_NO_STRAY_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr || bus_rd) |-> is_attached(bus_sel)); // R6
    AST_RSP_FROM_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> (rsp_byte == $past(bus_rdata))); // R4
    AST_IGNORED_OP: assert property (@(posedge clk) disable iff (!rst_n)
        (go && cmd.op != OP_WRITE && cmd.op != OP_READ) |=> (!bus_wr && !bus_rd)); // R5
endmodule

// File: rtl/jcb_periph.sv
`timescale 1ns/1ps
// Module: jcb_periph
// The three attached peripherals: control register, status view and probe selector.
// Assumes: read data is sampled by the dispatcher on the read strobe cycle.
module jcb_periph
    import jcb_pkg::*;
#(
    parameter int NPROBE    = 4,
    parameter int MUX_IDX_W = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [PID_W-1:0]         bus_sel,
    input  logic                     bus_wr,
    input  logic [DATA_W-1:0]        bus_wdata,
    input  logic [DATA_W-1:0]        sts_in,
    input  logic [NPROBE*DATA_W-1:0] probe_in,
    output logic [DATA_W-1:0]        bus_rdata,
    output logic [DATA_W-1:0]        ctrl_out,
    output logic [DATA_W-1:0]        mon_out
);
    logic [DATA_W-1:0]    ctrl_q;
    logic [DATA_W-1:0]    mux_q;
    logic [MUX_IDX_W-1:0] idx;

    // Register writes for the control and selector peripherals.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            mux_q  <= '0;
        end else if (bus_wr) begin
            if (bus_sel == PID_CTRL) ctrl_q <= bus_wdata;
            if (bus_sel == PID_MUX)  mux_q  <= bus_wdata;
        end
    end

    // Read data selection by peripheral number.
    always_comb begin
        case (bus_sel)
            PID_CTRL: bus_rdata = ctrl_q;
            PID_STAT: bus_rdata = sts_in;
            PID_MUX:  bus_rdata = mux_q;
            default:  bus_rdata = '0;
        endcase
    end

    assign idx = mux_q[MUX_IDX_W-1:0];

    // Probe byte routing; indices past the last probe give zero.
    always_comb begin
        mon_out = '0;
        for (int i = 0; i < NPROBE; i++)
            if (idx == MUX_IDX_W'(i)) mon_out = probe_in[i*DATA_W +: DATA_W];
    end

    assign ctrl_out = ctrl_q;

    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_sel == PID_CTRL) |=> $stable(ctrl_q)); // R7
    AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_sel == PID_CTRL) |=> (ctrl_out == $past(bus_wdata))); // R7
    AST_MUX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_sel == PID_MUX) |=> $stable(mux_q)); // R9
endmodule

// File: rtl/jtag_cmd_bridge.sv
`timescale 1ns/1ps
// Module: jtag_cmd_bridge
// Top level. Joins the scan-domain register, the update synchronizer,
// the command dispatcher and the peripheral set.
// Assumes: the TAP supplies the strobes aligned to tck, and each scan lasts
// much longer than the synchronizer latency in system clocks.
module jtag_cmd_bridge
    import jcb_pkg::*;
#(
    parameter int NPROBE    = 4,
    parameter int MUX_IDX_W = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tck,
    input  logic                     tap_rst_n,
    input  logic                     usr_sel,
    input  logic                     usr_capture,
    input  logic                     usr_shift,
    input  logic                     usr_update,
    input  logic                     tdi,
    output logic                     tdo,
    input  logic [DATA_W-1:0]        sts_in,
    input  logic [NPROBE*DATA_W-1:0] probe_in,
    output logic [DATA_W-1:0]        ctrl_out,
    output logic [DATA_W-1:0]        mon_out,
    output logic [PID_W-1:0]         bus_sel,
    output logic                     bus_wr,
    output logic                     bus_rd,
    output logic [DATA_W-1:0]        bus_wdata
);
    cmd_t              cmd;
    logic              upd_toggle;
    logic              go;
    logic [DATA_W-1:0] rsp_byte;
    logic [DATA_W-1:0] bus_rdata;

    jcb_shift u_shift (
        .tck(tck), .tap_rst_n(tap_rst_n), .usr_sel(usr_sel),
        .usr_capture(usr_capture), .usr_shift(usr_shift), .usr_update(usr_update),
        .tdi(tdi), .rsp_byte(rsp_byte), .tdo(tdo), .cmd(cmd), .upd_toggle(upd_toggle)
    );

    jcb_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .tog_in(upd_toggle), .pulse(go)
    );

    jcb_dispatch u_dispatch (
        .clk(clk), .rst_n(rst_n), .go(go), .cmd(cmd), .bus_rdata(bus_rdata),
        .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .rsp_byte(rsp_byte)
    );

    jcb_periph #(.NPROBE(NPROBE), .MUX_IDX_W(MUX_IDX_W)) u_periph (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .sts_in(sts_in), .probe_in(probe_in),
        .bus_rdata(bus_rdata), .ctrl_out(ctrl_out), .mon_out(mon_out)
    );
endmodule

// File: tb/jtag_cmd_bridge_bench.sv
`timescale 1ns/1ps
// Bench for jtag_cmd_bridge: directed corner cases, then seeded random commands.
module jtag_cmd_bridge_bench;
    localparam int NPROBE = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tck = 1'b0;
    logic tap_rst_n = 1'b0;
    logic usr_sel = 1'b0, usr_capture = 1'b0, usr_shift = 1'b0, usr_update = 1'b0;
    logic tdi = 1'b0;
    logic tdo;
    logic [7:0] sts_in = 8'h00;
    logic [NPROBE*8-1:0] probe_in = 32'h0;
    logic [7:0] ctrl_out, mon_out, bus_wdata;
    logic [3:0] bus_sel;
    logic bus_wr, bus_rd;

    int checks = 0;
    int errors = 0;
    int wr_cnt = 0;
    int rd_cnt = 0;
    logic [3:0] wr_sel_seen;
    logic [7:0] wr_dat_seen;

    // Reference model state
    logic [7:0] ctrl_m = 8'h00, mux_m = 8'h00, hdr_m = 8'h00, rsp_m = 8'h00;

    jtag_cmd_bridge #(.NPROBE(NPROBE)) u_jtag_cmd_bridge (
        .clk(clk), .rst_n(rst_n), .tck(tck), .tap_rst_n(tap_rst_n),
        .usr_sel(usr_sel), .usr_capture(usr_capture), .usr_shift(usr_shift),
        .usr_update(usr_update), .tdi(tdi), .tdo(tdo), .sts_in(sts_in),
        .probe_in(probe_in), .ctrl_out(ctrl_out), .mon_out(mon_out),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata)
    );

    always #5 clk = ~clk;

    // Strobe monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (bus_wr) begin
                wr_cnt = wr_cnt + 1;
                wr_sel_seen = bus_sel;
                wr_dat_seen = bus_wdata;
            end
            if (bus_rd) rd_cnt = rd_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic att(input logic [3:0] p);
        return p <= 4'd2;
    endfunction

    function automatic logic [7:0] read_val(input logic [3:0] p);
        case (p)
            4'd0: return ctrl_m;
            4'd1: return sts_in;
            4'd2: return mux_m;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] exp_mon();
        if (mux_m[2:0] < NPROBE) return probe_in[mux_m[2:0]*8 +: 8];
        return 8'h00;
    endfunction

    task automatic tck_pulse();
        #20 tck = 1'b1;
        #20 tck = 1'b0;
    endtask

    // One scan: capture, 16 shifts (optional deselected stall), then update.
    task automatic scan(input logic [15:0] w, input bit stall, input bit sel_upd, output logic [15:0] got);
        usr_sel = 1'b1; usr_capture = 1'b1;
        tck_pulse();
        usr_capture = 1'b0;
        for (int i = 0; i < 16; i++) begin
            if (stall && i == 8) begin
                for (int k = 0; k < 5; k++) begin
                    usr_sel = 1'b0; usr_shift = 1'b1; usr_capture = k[0];
                    tdi = $urandom_range(0, 1);
                    tck_pulse();
                end
                usr_capture = 1'b0;
            end
            usr_sel = 1'b1; usr_shift = 1'b1; tdi = w[i];
            #5 got[i] = tdo;
            tck_pulse();
        end
        usr_shift = 1'b0; usr_sel = sel_upd; usr_update = 1'b1;
        tck_pulse();
        usr_update = 1'b0; usr_sel = 1'b0;
        tck_pulse();
    endtask

    task automatic do_cmd(input logic [15:0] w, input bit stall, input bit commit);
        logic [15:0] got, prev;
        logic [3:0] p, op;
        logic [7:0] d;
        bit ewr, erd;
        int wr0, rd0;
        p = w[15:12]; op = w[11:8]; d = w[7:0];
        prev = {hdr_m, rsp_m};
        wr0 = wr_cnt; rd0 = rd_cnt;
        scan(w, stall, commit, got);
        chk(got == prev, "R4 R1 capture echo", got, prev);
        ewr = commit && op == 4'h0 && att(p);
        erd = commit && op == 4'h1 && att(p);
        if (commit) begin
            if (ewr && p == 4'd0) ctrl_m = d;
            if (ewr && p == 4'd2) mux_m = d;
            rsp_m = erd ? read_val(p) : 8'h00;
            hdr_m = w[15:8];
        end
        repeat (12) @(negedge clk);
        chk(wr_cnt - wr0 == int'(ewr), "R3 R5 R6 R2 write strobes", 16'(wr_cnt - wr0), 16'(ewr));
        chk(rd_cnt - rd0 == int'(erd), "R4 R5 R6 R2 read strobes", 16'(rd_cnt - rd0), 16'(erd));
        if (ewr) chk({wr_sel_seen, wr_dat_seen} == {p, d}, "R3 write fields",
                     {4'h0, wr_sel_seen, wr_dat_seen}, {4'h0, p, d});
        chk(ctrl_out == ctrl_m, "R7 R8 ctrl_out", {8'h0, ctrl_out}, {8'h0, ctrl_m});
        chk(mon_out == exp_mon(), "R9 mon_out", {8'h0, mon_out}, {8'h0, exp_mon()});
    endtask

    bit done = 1'b0;

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] w;
        void'($urandom(32'd4242));
        probe_in = 32'hD4C3B2A1;
        sts_in   = 8'h5A;
        repeat (3) tck_pulse();
        repeat (5) @(negedge clk);
        tap_rst_n = 1'b1;
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(ctrl_out == 8'h00, "R10 ctrl reset", {8'h0, ctrl_out}, 16'h0);
        chk(mon_out == 8'hA1, "R10 mon reset", {8'h0, mon_out}, 16'h00A1);
        chk(tdo == 1'b0, "R10 tdo reset", {15'h0, tdo}, 16'h0);
        // Directed corner cases (first capture checks 0x0000 for R10)
        do_cmd(16'h2034, 0, 1);   // R9 index 4 -> zero
        do_cmd(16'h0055, 0, 1);   // R7 write ctrl
        do_cmd(16'h0100, 0, 1);   // R7 read ctrl
        do_cmd(16'h1100, 0, 1);   // R8 read status
        do_cmd(16'h10AA, 0, 1);   // R8 write status, no effect
        do_cmd(16'h1100, 0, 1);
        do_cmd(16'h7012, 0, 1);   // R6 unattached write
        do_cmd(16'h7100, 0, 1);   // R6 unattached read
        do_cmd(16'h0512, 0, 1);   // R5 ignored opcode
        do_cmd(16'h2002, 0, 1);   // R9 select byte 2
        do_cmd(16'h2100, 1, 1);   // R1 deselected stall mid-scan
        do_cmd(16'h00EE, 0, 0);   // R2 update while deselected
        do_cmd(16'h0100, 0, 1);
        // Random commands
        for (int n = 0; n < 60; n++) begin
            w[15:12] = $urandom_range(0, 15);
            if (($urandom_range(0, 3)) < 3) w[15:12] = $urandom_range(0, 2);
            w[11:8] = ($urandom_range(0, 4) == 0) ? 4'($urandom_range(2, 15)) : 4'($urandom_range(0, 1));
            w[7:0] = $urandom_range(0, 255);
            if ($urandom_range(0, 7) == 0) sts_in = $urandom_range(0, 255);
            do_cmd(w, $urandom_range(0, 9) == 0, $urandom_range(0, 9) != 0);
        end
        do_cmd(16'h3F00, 0, 1);   // flush last response
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule